// File: doc/BRIEF.md
# Grouped Carry-Skip Adder

This block adds two unsigned operands and a carry-in. It produces a sum of the same width and a carry-out. Every operand bit is first classified as kill, generate or propagate. The bits are then split into fixed groups of four.

Inside a group the carry ripples bit by bit through a local chain. Every group also forms an all-propagate flag, and all groups form this flag at the same time. When the flag is set, a mux sends the group's incoming carry straight to its outgoing carry and does not wait for the local chain. The longest path therefore starts in the chain of the lowest group, passes the skip muxes of the middle groups, and ends in the chain of the highest group.

An output register captures the sum and the carry-out so that the result can be sampled cleanly. The register can be removed with a parameter. The operand width must be a multiple of the group size; any other value stops elaboration with an error. The default width is 16 bits.

Top module: `skip_adder`

## Requirements
- R1: With the output register enabled, `sum_q` equals the low WIDTH bits of `op_a + op_b + carry_in`, where the inputs are those present at the rising clock edge before the one being observed.
- R2: `carry_q` equals bit WIDTH of that same sum. This is the carry leaving the most significant group.
- R3: When every bit has `op_a ^ op_b == 1` (all bits propagate), the carry passes unchanged to the output. With `carry_in = 1` the result is sum 0 and carry 1. With `carry_in = 0` the result is sum all ones and carry 0.
- R4: When both operands are 0 (every bit kills), no carry leaves the adder. The sum equals `carry_in` in bit 0 and 0 in every other bit, and the carry-out is 0.
- R5: When both operands are all ones (every bit generates), the carry-out is 1 and the sum equals all ones with bit 0 replaced by `carry_in`.
- R6: While `rst_n` is low, `sum_q` and `carry_q` are 0. They are cleared at once, without waiting for a clock edge.
- R7: The outputs change only at a rising clock edge. New operands do not show at the outputs before the next edge.
- R8: A carry made in the lowest group and propagated by all higher groups reaches `carry_q`, and the bits between its source and the carry-out read 0 in the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | WIDTH | Registered sum |
| carry_q | output | 1 | Registered carry-out |

## Verification
The main test uses random operand pairs with a random carry-in, which mostly gives mixed kill, generate and propagate patterns. These pairs show whether the local chains and the group boundaries agree with a plain integer sum.

Directed cases isolate single mechanisms:
- All-propagate words with either carry-in value exercise only the skip muxes.
- All-kill words and all-generate words show that the chain stops and starts correctly.
- A carry generated in bit 0 that must cross every higher group tells a working skip path from one that drops or duplicates the carry.

// File: rtl/skip_adder_pkg.sv
package skip_adder_pkg;

  typedef struct packed {
    logic kill;
    logic gen;
    logic prop;
  } bit_class_t;

  function automatic bit_class_t classify(input logic a, input logic b);
    bit_class_t r;
    r.kill = ~a & ~b;
    r.gen  = a & b;
    r.prop = a ^ b;
    return r;
  endfunction

endpackage

// File: rtl/skip_bitcell.sv
module skip_bitcell
  import skip_adder_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output logic kill_o,
  output logic gen_o,
  output logic prop_o
);
  bit_class_t cls;

  always_comb begin
    cls    = classify(a_i, b_i);
    kill_o = cls.kill;
    gen_o  = cls.gen;
    prop_o = cls.prop;
  end
endmodule

// File: rtl/skip_group.sv
module skip_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] kill_i,
  input  logic [GW-1:0] gen_i,
  input  logic [GW-1:0] prop_i,
  input  logic          cin_i,
  output logic [GW-1:0] bit_cin_o,
  output logic          grp_prop_o,
  output logic          cout_o
);
  logic [GW:0] chain;

  assign chain[0] = cin_i;

  generate
    for (genvar i = 0; i < GW; i++) begin : g_ripple
      assign chain[i+1] = gen_i[i] | (~kill_i[i] & chain[i]);
    end
  endgenerate

  assign bit_cin_o  = chain[GW-1:0];
  assign grp_prop_o = &prop_i;
  assign cout_o     = grp_prop_o ? cin_i : chain[GW];
endmodule

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int WIDTH   = 16,
  parameter int GRP     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_q
);
  localparam int NGRP = WIDTH / GRP;

  generate
    if (WIDTH % GRP != 0) begin : g_bad_width
      $error("skip_adder: WIDTH must be a multiple of GRP");
    end
  endgenerate

  logic [WIDTH-1:0] kill_v, gen_v, prop_v, bit_cin;
  logic [NGRP:0]    grp_c;
  logic [NGRP-1:0]  grp_prop;
  logic [WIDTH-1:0] sum_d;
  logic             carry_d;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      skip_bitcell u_cell (
        .a_i    (op_a[i]),
        .b_i    (op_b[i]),
        .kill_o (kill_v[i]),
        .gen_o  (gen_v[i]),
        .prop_o (prop_v[i])
      );
    end
  endgenerate

  assign grp_c[0] = carry_in;

  generate
    for (genvar j = 0; j < NGRP; j++) begin : g_grp
      skip_group #(.GW(GRP)) u_grp (
        .kill_i     (kill_v[j*GRP +: GRP]),
        .gen_i      (gen_v[j*GRP +: GRP]),
        .prop_i     (prop_v[j*GRP +: GRP]),
        .cin_i      (grp_c[j]),
        .bit_cin_o  (bit_cin[j*GRP +: GRP]),
        .grp_prop_o (grp_prop[j]),
        .cout_o     (grp_c[j+1])
      );
    end
  endgenerate

  always_comb begin
    sum_d   = prop_v ^ bit_cin;
    carry_d = grp_c[NGRP];
  end

  generate
    if (REG_OUT) begin : g_reg
      logic             load_en;
      logic [WIDTH-1:0] sum_r;
      logic             carry_r;

      assign load_en = 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_r   <= '0;
          carry_r <= 1'b0;
        end else if (load_en) begin
          sum_r   <= sum_d;
          carry_r <= carry_d;
        end
      end

      assign sum_q   = sum_r;
      assign carry_q = carry_r;
    end else begin : g_comb
      assign sum_q   = sum_d;
      assign carry_q = carry_d;
    end
  endgenerate

  logic unused_grp;
  assign unused_grp = ^grp_prop;
endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_q
);
  logic [WIDTH-1:0] a_d, b_d;
  logic             c_d;
  logic             seen;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_d  <= '0;
          b_d  <= '0;
          c_d  <= 1'b0;
          seen <= 1'b0;
        end else begin
          a_d  <= op_a;
          b_d  <= op_b;
          c_d  <= carry_in;
          seen <= 1'b1;
        end
      end
    end else begin : g_nodly
      assign a_d  = op_a;
      assign b_d  = op_b;
      assign c_d  = carry_in;
      assign seen = 1'b1;
    end
  endgenerate

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_d} + {1'b0, b_d} + {{WIDTH{1'b0}}, c_d};

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (sum_q == ref_sum[WIDTH-1:0]));  // R1
  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (carry_q == ref_sum[WIDTH]));  // R2
  AST_FULL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ((a_d ^ b_d) == {WIDTH{1'b1}})) |-> (carry_q == c_d && sum_q == {WIDTH{~c_d}}));  // R3
  AST_ALL_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ((a_d | b_d) == '0)) |-> !carry_q);  // R4
  AST_ALL_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ((a_d & b_d) == {WIDTH{1'b1}})) |-> carry_q);  // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (sum_q == '0 && !carry_q));  // R6
endmodule

bind skip_adder skip_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .sum_q    (sum_q),
  .carry_q  (carry_q)
);

// File: tb/sim_skip_adder.sv
module sim_skip_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic         carry_in;
  logic [W-1:0] sum_q;
  logic         carry_q;

  int n_run  = 0;
  int n_fail = 0;

  skip_adder #(.WIDTH(W), .GRP(4), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum_q(sum_q), .carry_q(carry_q)
  );

  always #5 clk = ~clk;

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    check(req, {carry_q, sum_q}, ref_add(a, b, c));
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W:0] prev;
    rst_n = 1'b0; op_a = '1; op_b = '1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 reset", {carry_q, sum_q}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    apply("R1 zeros", '0, '0, 1'b0);
    apply("R3 all-prop cin1", 16'hAAAA, 16'h5555, 1'b1);
    check("R3 sum zero", {1'b0, sum_q}, '0);
    apply("R3 all-prop cin0", 16'h0F0F, 16'hF0F0, 1'b0);
    check("R3 carry low", {{W{1'b0}}, carry_q}, '0);
    apply("R4 all-kill cin1", '0, '0, 1'b1);
    check("R4 sum one", {carry_q, sum_q}, 17'h00001);
    apply("R5 all-gen cin0", '1, '1, 1'b0);
    check("R5 result", {carry_q, sum_q}, 17'h1FFFE);
    apply("R5 all-gen cin1", '1, '1, 1'b1);
    apply("R8 skip from bit0", 16'hFFFF, 16'h0001, 1'b0);
    check("R8 carry out", {carry_q, sum_q}, 17'h10000);
    apply("R8 skip two groups", 16'h00FF, 16'h0001, 1'b0);
    apply("R2 boundary", 16'h000F, 16'h0001, 1'b0);
    apply("R2 top only", 16'h8000, 16'h8000, 1'b0);

    // R7: new operands must not show before the next edge
    op_a = 16'h1234; op_b = 16'h1111; carry_in = 1'b0;
    @(negedge clk);
    prev = {carry_q, sum_q};
    op_a = 16'h4321; op_b = 16'h0101; carry_in = 1'b1;
    #3;
    check("R7 hold", {carry_q, sum_q}, prev);
    @(negedge clk);
    check("R7 update", {carry_q, sum_q}, ref_add(16'h4321, 16'h0101, 1'b1));

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      apply("R1 R2 random", W'($urandom), W'($urandom), 1'($urandom));
    end

    // R6: reset clears at once, between edges
    apply("R6 prefill", '1, '1, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    check("R6 async clear", {carry_q, sum_q}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule